// File: doc/BRIEF.md
# Unified Translation Buffer Associative Lookup

This block holds the unified address-translation table of a processor memory unit: 64 fully associative entries, each with a virtual page number, an address-space identifier, a physical page number and a 9-bit flag field. Every entry compares itself against a requested virtual address in the same cycle. The result is registered and shows up one cycle after the request strobe. It is a single hit with the index of the entry, the translated physical address and the entry flags, or a miss, or a multi-hit.

The table is filled in three ways. A load command copies two staging registers into the entry that the replacement counter points at. Direct writes go to the address array or the data array of one indexed entry. An associative address-array write searches for the entry that matches the written page and updates only its valid and dirty bits. A control write sets the replacement counter and its boundary, and can invalidate every entry at once. Exception sequencing is left to the surrounding logic. This block reports only the lookup outcome and the associative-write multi-hit.

Top module: `utlb_cam`

## Requirements
- R1: Flag bit layout: bit 8 valid, bits 7:6 page-size code, bits 5:4 protection, bit 3 cacheable, bit 2 dirty, bit 1 shared, bit 0 write-through. The page number occupies address bits 31:10, the address-space identifier is 8 bits, and the physical page number occupies bits 28:10.
- R2: Size code 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. Page bits below the page size are excluded from the compare. The physical address takes its page bits from the entry and its offset bits from the request.
- R3: An entry matches when it is valid, the masked page numbers are equal, and either its shared bit is set or its identifier equals `cur_asid_i`.
- R4: While `ignore_asid_i` is high during a lookup, the identifier and shared bit are not used. Only valid and the masked page number are compared.
- R5: One cycle after `lookup_req_i`, `res_valid_o` pulses with exactly one of hit, miss or multi (two or more matching entries). On a miss or a multi-hit, the index, address and flags read zero.
- R6: `load_i` writes the entry at the replacement counter. The page number (bits 31:10) and identifier (bits 7:0) come from `stage_hi_i`. The physical page number (bits 28:10) and flags (bits 8:0) come from `stage_lo_i`.
- R7: An associative address-array write (`arr_wr_i`, `arr_assoc_i`, `arr_data_i` low) finds the single entry that matches `arr_wdata_i[31:10]` under `cur_asid_i`. It sets that entry's valid bit from data bit 8 and its dirty bit from data bit 9, and leaves its other fields unchanged.
- R8: Each lookup advances the replacement counter (`repl_idx_o`, reset 0). The counter returns to 0 when the incremented value equals the boundary or reaches 64. A control write loads the counter from bits 15:10 and the boundary from bits 23:18. The control write takes precedence over a lookup in the same cycle.
- R9: A control write with bit 2 set clears the valid bit of every entry. This takes precedence over any entry write in the same cycle.
- R10: An associative write that matches two or more entries pulses `assoc_multi_o` one cycle later and changes no entry.
- R11: A direct address-array write to index `arr_idx_i` sets the page number (31:10), identifier (7:0), valid (bit 8) and dirty (bit 9). A direct data-array write sets the physical page number (28:10) and all nine flags (8:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_asid_i | input | 8 | Current address-space identifier |
| lookup_req_i | input | 1 | Lookup strobe |
| lookup_vaddr_i | input | 32 | Virtual address to translate |
| ignore_asid_i | input | 1 | Identifier-ignore lookup mode |
| load_i | input | 1 | Load entry from staging registers |
| stage_hi_i | input | 32 | Page number and identifier staging |
| stage_lo_i | input | 32 | Physical page and flags staging |
| arr_wr_i | input | 1 | Direct array write strobe |
| arr_data_i | input | 1 | 1 selects data array, 0 address array |
| arr_assoc_i | input | 1 | Associative address-array write |
| arr_idx_i | input | 6 | Entry index for direct writes |
| arr_wdata_i | input | 32 | Array write data |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 32 | Control data: counter, boundary, invalidate |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Single hit |
| res_miss_o | output | 1 | No matching entry |
| res_multi_o | output | 1 | Two or more matching entries |
| res_idx_o | output | 6 | Index of hitting entry |
| res_paddr_o | output | 29 | Translated physical address |
| res_flags_o | output | 9 | Flags of hitting entry |
| repl_idx_o | output | 6 | Replacement counter |
| assoc_multi_o | output | 1 | Associative write found multiple entries |

## Verification
A lookup and a control write can fall in the same cycle. The lookup wants to advance the replacement counter and the control write wants to load it. The bench drives `lookup_req_i` and `ctrl_wr_i` on the same edge, then checks that the counter holds the written value and not the advanced one. It also checks that the lookup itself still returns its expected result through the scoreboard. A load and a lookup in the same cycle are also provoked. The expected outcome is that the lookup sees the table as it was before the load, and the load lands at the pre-advance counter value.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int FLAG_W = 9;
  localparam int F_V    = 8;
  localparam int F_SZH  = 7;
  localparam int F_SZL  = 6;
  localparam int F_D    = 2;
  localparam int F_SH   = 1;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } tlb_ent_t;

  // page-number compare mask for a size code
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      2'd0:    m = '1;
      2'd1:    m = m << 2;
      2'd2:    m = m << 6;
      default: m = m << 10;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tlb_ent_t [ENTRIES-1:0] tbl_i,
  input  logic [VPN_W-1:0]       vpn_i,
  input  logic [ASID_W-1:0]      asid_i,
  input  logic                   ign_asid_i,
  output logic [ENTRIES-1:0]     hit_vec_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] msk;
    logic             id_ok;
    assign msk   = size_mask({tbl_i[g].flags[F_SZH], tbl_i[g].flags[F_SZL]});
    assign id_ok = ign_asid_i | tbl_i[g].flags[F_SH] | (tbl_i[g].asid == asid_i);
    assign hit_vec_o[g] = tbl_i[g].flags[F_V] & id_ok &
                          (((tbl_i[g].vpn ^ vpn_i) & msk) == '0);
  end
endmodule

// File: rtl/utlb_enc.sv
module utlb_enc #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec_i,
  output logic               any_o,
  output logic               multi_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign any_o   = |hit_vec_i;
  assign multi_o = |(hit_vec_i & (hit_vec_i - ENTRIES'(1)));

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec_i[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/utlb_repl.sv
module utlb_repl #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_cnt_i,
  input  logic [IDX_W-1:0] set_bnd_i,
  output logic [IDX_W-1:0] cnt_o
);
  logic [IDX_W-1:0] cnt_q, bnd_q;
  logic [IDX_W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + (IDX_W+1)'(1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bnd_q <= '0;
    end else if (set_i) begin
      cnt_q <= set_cnt_i;
      bnd_q <= set_bnd_i;
    end else if (adv_i) begin
      if (nxt == {1'b0, bnd_q} || nxt == (IDX_W+1)'(ENTRIES)) cnt_q <= '0;
      else cnt_q <= nxt[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/utlb_cam.sv
module utlb_cam
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CNT_LSB = 10,
  parameter int BND_LSB = 18,
  parameter int INV_BIT = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              lookup_req_i,
  input  logic [31:0]       lookup_vaddr_i,
  input  logic              ignore_asid_i,
  input  logic              load_i,
  input  logic [31:0]       stage_hi_i,
  input  logic [31:0]       stage_lo_i,
  input  logic              arr_wr_i,
  input  logic              arr_data_i,
  input  logic              arr_assoc_i,
  input  logic [IDX_W-1:0]  arr_idx_i,
  input  logic [31:0]       arr_wdata_i,
  input  logic              ctrl_wr_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic              res_miss_o,
  output logic              res_multi_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic [PA_W-1:0]   res_paddr_o,
  output logic [FLAG_W-1:0] res_flags_o,
  output logic [IDX_W-1:0]  repl_idx_o,
  output logic              assoc_multi_o
);
  tlb_ent_t [ENTRIES-1:0] tbl_q;

  logic [ENTRIES-1:0] lk_vec, as_vec;
  logic               lk_any, lk_multi, as_any, as_multi;
  logic [IDX_W-1:0]   lk_idx, as_idx;

  utlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .tbl_i(tbl_q), .vpn_i(lookup_vaddr_i[31:10]), .asid_i(cur_asid_i),
    .ign_asid_i(ignore_asid_i), .hit_vec_o(lk_vec));
  utlb_enc #(.ENTRIES(ENTRIES)) u_lk_enc (
    .hit_vec_i(lk_vec), .any_o(lk_any), .multi_o(lk_multi), .idx_o(lk_idx));

  utlb_match #(.ENTRIES(ENTRIES)) u_as_match (
    .tbl_i(tbl_q), .vpn_i(arr_wdata_i[31:10]), .asid_i(cur_asid_i),
    .ign_asid_i(1'b0), .hit_vec_o(as_vec));
  utlb_enc #(.ENTRIES(ENTRIES)) u_as_enc (
    .hit_vec_i(as_vec), .any_o(as_any), .multi_o(as_multi), .idx_o(as_idx));

  utlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk_i, .rst_ni, .adv_i(lookup_req_i), .set_i(ctrl_wr_i),
    .set_cnt_i(ctrl_wdata_i[CNT_LSB +: IDX_W]),
    .set_bnd_i(ctrl_wdata_i[BND_LSB +: IDX_W]),
    .cnt_o(repl_idx_o));

  logic inv_all, addr_wr, data_wr, assoc_wr;
  assign inv_all  = ctrl_wr_i & ctrl_wdata_i[INV_BIT];
  assign addr_wr  = arr_wr_i & ~arr_data_i & ~arr_assoc_i;
  assign data_wr  = arr_wr_i &  arr_data_i;
  assign assoc_wr = arr_wr_i & ~arr_data_i &  arr_assoc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (inv_all) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i].flags[F_V] <= 1'b0;
    end else if (load_i) begin
      tbl_q[repl_idx_o].vpn   <= stage_hi_i[31:10];
      tbl_q[repl_idx_o].asid  <= stage_hi_i[ASID_W-1:0];
      tbl_q[repl_idx_o].ppn   <= stage_lo_i[28:10];
      tbl_q[repl_idx_o].flags <= stage_lo_i[FLAG_W-1:0];
    end else if (addr_wr) begin
      tbl_q[arr_idx_i].vpn        <= arr_wdata_i[31:10];
      tbl_q[arr_idx_i].asid       <= arr_wdata_i[ASID_W-1:0];
      tbl_q[arr_idx_i].flags[F_V] <= arr_wdata_i[8];
      tbl_q[arr_idx_i].flags[F_D] <= arr_wdata_i[9];
    end else if (data_wr) begin
      tbl_q[arr_idx_i].ppn   <= arr_wdata_i[28:10];
      tbl_q[arr_idx_i].flags <= arr_wdata_i[FLAG_W-1:0];
    end else if (assoc_wr && as_any && !as_multi) begin
      tbl_q[as_idx].flags[F_V] <= arr_wdata_i[8];
      tbl_q[as_idx].flags[F_D] <= arr_wdata_i[9];
    end
  end

  // translated address of the single hit
  logic [VPN_W-1:0] hit_msk;
  logic [PA_W-1:0]  hit_pa;
  assign hit_msk = size_mask({tbl_q[lk_idx].flags[F_SZH], tbl_q[lk_idx].flags[F_SZL]});
  assign hit_pa  = {(tbl_q[lk_idx].ppn & hit_msk[PPN_W-1:0]) |
                    (lookup_vaddr_i[28:10] & ~hit_msk[PPN_W-1:0]),
                    lookup_vaddr_i[9:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o   <= 1'b0;
      res_hit_o     <= 1'b0;
      res_miss_o    <= 1'b0;
      res_multi_o   <= 1'b0;
      res_idx_o     <= '0;
      res_paddr_o   <= '0;
      res_flags_o   <= '0;
      assoc_multi_o <= 1'b0;
    end else begin
      assoc_multi_o <= assoc_wr & as_multi;
      res_valid_o   <= lookup_req_i;
      if (lookup_req_i) begin
        res_hit_o   <= lk_any & ~lk_multi;
        res_miss_o  <= ~lk_any;
        res_multi_o <= lk_multi;
        res_idx_o   <= (lk_any & ~lk_multi) ? lk_idx : '0;
        res_paddr_o <= (lk_any & ~lk_multi) ? hit_pa : '0;
        res_flags_o <= (lk_any & ~lk_multi) ? tbl_q[lk_idx].flags : '0;
      end
    end
  end
endmodule

// File: rtl/utlb_cam_chk.sv
module utlb_cam_chk #(
  parameter int IDX_W = 6,
  parameter int PA_W  = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_req_i,
  input logic             arr_wr_i,
  input logic             arr_data_i,
  input logic             arr_assoc_i,
  input logic             ctrl_wr_i,
  input logic [31:0]      ctrl_wdata_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic             res_miss_o,
  input logic             res_multi_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic [PA_W-1:0]  res_paddr_o,
  input logic [8:0]       res_flags_o,
  input logic [IDX_W-1:0] repl_idx_o,
  input logic             assoc_multi_o
);
  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $countones({res_hit_o, res_miss_o, res_multi_o}) == 1);

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_req_i |=> res_valid_o);

  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_req_i |=> !res_valid_o);

  p_zero_on_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_idx_o == '0 && res_paddr_o == '0 && res_flags_o == '0));

  p_ctrl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> repl_idx_o == $past(ctrl_wdata_i[10 +: IDX_W]));

  p_counter_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lookup_req_i && !ctrl_wr_i) |=> $stable(repl_idx_o));

  p_flush_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_req_i && $past(ctrl_wr_i && ctrl_wdata_i[2])) |=> res_miss_o);

  p_assoc_multi_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    assoc_multi_o |-> $past(arr_wr_i && arr_assoc_i && !arr_data_i));
endmodule

bind utlb_cam utlb_cam_chk #(.IDX_W(IDX_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/utlb_cam_bench.sv
module utlb_cam_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  cur_asid_i = '0;
  logic        lookup_req_i = 1'b0, ignore_asid_i = 1'b0, load_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0, stage_hi_i = '0, stage_lo_i = '0;
  logic        arr_wr_i = 1'b0, arr_data_i = 1'b0, arr_assoc_i = 1'b0;
  logic [5:0]  arr_idx_i = '0;
  logic [31:0] arr_wdata_i = '0;
  logic        ctrl_wr_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic        res_valid_o, res_hit_o, res_miss_o, res_multi_o, assoc_multi_o;
  logic [5:0]  res_idx_o, repl_idx_o;
  logic [28:0] res_paddr_o;
  logic [8:0]  res_flags_o;

  utlb_cam u_utlb_cam (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [1:0]  kind;  // 0 hit, 1 miss, 2 multi
    logic [5:0]  idx;
    logic [28:0] pa;
    logic [8:0]  fl;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (sb_q.size() == 0) chk(1'b0, "R5 unexpected result", 1, 0);
      else begin
        exp_t e;
        logic [1:0] k;
        e = sb_q.pop_front();
        k = res_hit_o ? 2'd0 : res_miss_o ? 2'd1 : 2'd2;
        chk(k == e.kind && res_idx_o == e.idx && res_paddr_o == e.pa && res_flags_o == e.fl,
            e.tag, {k, res_idx_o, res_paddr_o, res_flags_o}, {e.kind, e.idx, e.pa, e.fl});
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic ign,
                        input logic [1:0] kind, input logic [5:0] idx, input logic [28:0] pa,
                        input logic [8:0] fl, input string tag);
    exp_t e;
    @(negedge clk_i);
    e.kind = kind; e.idx = idx; e.pa = pa; e.fl = fl; e.tag = tag;
    sb_q.push_back(e);
    lookup_vaddr_i = va; cur_asid_i = asid; ignore_asid_i = ign; lookup_req_i = 1'b1;
    @(negedge clk_i);
    lookup_req_i = 1'b0; ignore_asid_i = 1'b0;
  endtask

  task automatic ctrl_write(input logic [31:0] d);
    @(negedge clk_i);
    ctrl_wdata_i = d; ctrl_wr_i = 1'b1;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic arr_write(input logic data, input logic assoc, input logic [5:0] idx,
                           input logic [31:0] d, input logic [7:0] asid);
    @(negedge clk_i);
    arr_data_i = data; arr_assoc_i = assoc; arr_idx_i = idx; arr_wdata_i = d;
    cur_asid_i = asid; arr_wr_i = 1'b1;
    @(negedge clk_i);
    arr_wr_i = 1'b0; arr_assoc_i = 1'b0;
  endtask

  task automatic load_entry(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk_i);
    stage_hi_i = hi; stage_lo_i = lo; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  function automatic logic [31:0] cw(input int cnt, input int bnd, input bit inv);
    return (32'(bnd) << 18) | (32'(cnt) << 10) | (inv ? 32'h4 : 32'h0);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(res_valid_o == 1'b0 && repl_idx_o == 6'd0 && assoc_multi_o == 1'b0,
        "R8 reset state", {res_valid_o, repl_idx_o, assoc_multi_o}, 0);

    // R6 load at counter 0: 4K page, asid 11, valid
    load_entry(32'h0040_0011, 32'h0123_4140);
    chk(repl_idx_o == 6'd0, "R8 load does not advance", repl_idx_o, 0);
    lookup(32'h0040_0ABC, 8'h11, 1'b0, 2'd0, 6'd0, 29'h0123_4ABC, 9'h140, "R6 R2 load then hit 4K");
    chk(repl_idx_o == 6'd1, "R8 advance on lookup", repl_idx_o, 1);
    lookup(32'h0080_0000, 8'h11, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R5 miss on other page");
    lookup(32'h0040_0ABC, 8'h22, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R3 asid mismatch miss");
    lookup(32'h0040_0ABC, 8'h22, 1'b1, 2'd0, 6'd0, 29'h0123_4ABC, 9'h140, "R4 ignore asid hit");

    // R11 direct writes to entry 5: 1M shared page
    arr_write(1'b1, 1'b0, 6'd5, 32'h0050_01C2, 8'h0);
    arr_write(1'b0, 1'b0, 6'd5, 32'h1000_0133, 8'h0);
    lookup(32'h100A_BCDE, 8'h77, 1'b0, 2'd0, 6'd5, 29'h005A_BCDE, 9'h1C2, "R3 R11 shared 1M hit");
    lookup(32'h1010_0000, 8'h77, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R2 outside 1M page miss");

    // entry 9: 1K page overlapping entry 0
    arr_write(1'b1, 1'b0, 6'd9, 32'h0000_0100, 8'h0);
    arr_write(1'b0, 1'b0, 6'd9, 32'h0040_0111, 8'h0);
    lookup(32'h0040_0000, 8'h11, 1'b0, 2'd2, 6'd0, 29'h0, 9'h0, "R5 multi-hit");
    lookup(32'h0040_0800, 8'h11, 1'b0, 2'd0, 6'd0, 29'h0123_4800, 9'h140, "R2 1K mask separates");

    // R7 associative write on entry 5
    arr_write(1'b0, 1'b1, 6'd0, 32'h1000_0300, 8'h77);
    chk(assoc_multi_o == 1'b0, "R7 single match no multi flag", assoc_multi_o, 0);
    lookup(32'h1000_0004, 8'h77, 1'b0, 2'd0, 6'd5, 29'h0000_0004 | 29'h0050_0000, 9'h1C6, "R7 dirty set");
    arr_write(1'b0, 1'b1, 6'd0, 32'h1000_0000, 8'h77);
    lookup(32'h1000_0004, 8'h77, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R7 valid cleared");

    // R10 associative multi-hit
    arr_write(1'b0, 1'b1, 6'd0, 32'h0040_0000, 8'h11);
    chk(assoc_multi_o == 1'b1, "R10 assoc multi flag", assoc_multi_o, 1);
    @(negedge clk_i);
    chk(assoc_multi_o == 1'b0, "R10 assoc multi single pulse", assoc_multi_o, 0);
    lookup(32'h0040_0000, 8'h11, 1'b0, 2'd2, 6'd0, 29'h0, 9'h0, "R10 entries unchanged");

    // R8 counter boundary and wrap
    ctrl_write(cw(5, 7, 0));
    chk(repl_idx_o == 6'd5, "R8 ctrl sets counter", repl_idx_o, 5);
    lookup(32'h0, 8'h0, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R5 miss at page 0");
    chk(repl_idx_o == 6'd6, "R8 count to 6", repl_idx_o, 6);
    lookup(32'h0, 8'h0, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R5 miss at page 0");
    chk(repl_idx_o == 6'd0, "R8 wrap at boundary", repl_idx_o, 0);
    ctrl_write(cw(62, 0, 0));
    lookup(32'h0, 8'h0, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R5 miss at page 0");
    chk(repl_idx_o == 6'd63, "R8 count to 63", repl_idx_o, 63);
    lookup(32'h0, 8'h0, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R5 miss at page 0");
    chk(repl_idx_o == 6'd0, "R8 wrap at 64", repl_idx_o, 0);

    // R8 control write and lookup in the same cycle
    begin
      exp_t e;
      @(negedge clk_i);
      e.kind = 2'd0; e.idx = 6'd0; e.pa = 29'h0123_4ABC; e.fl = 9'h140; e.tag = "R8 lookup beside ctrl write";
      sb_q.push_back(e);
      lookup_vaddr_i = 32'h0040_0ABC; cur_asid_i = 8'h33; ignore_asid_i = 1'b1; lookup_req_i = 1'b1;
      ctrl_wdata_i = cw(10, 0, 0); ctrl_wr_i = 1'b1;
      @(negedge clk_i);
      lookup_req_i = 1'b0; ignore_asid_i = 1'b0; ctrl_wr_i = 1'b0;
      chk(repl_idx_o == 6'd10, "R8 ctrl write wins over advance", repl_idx_o, 10);
    end

    // R6 load and lookup in the same cycle: lookup sees old table
    begin
      exp_t e;
      @(negedge clk_i);
      e.kind = 2'd1; e.idx = 6'd0; e.pa = 29'h0; e.fl = 9'h0; e.tag = "R6 lookup beside load sees old table";
      sb_q.push_back(e);
      lookup_vaddr_i = 32'h0300_0010; cur_asid_i = 8'h44; lookup_req_i = 1'b1;
      stage_hi_i = 32'h0300_0044; stage_lo_i = 32'h0077_7140; load_i = 1'b1;
      @(negedge clk_i);
      lookup_req_i = 1'b0; load_i = 1'b0;
    end
    lookup(32'h0300_0010, 8'h44, 1'b0, 2'd0, 6'd10, 29'h0077_7010, 9'h140, "R6 load at pre-advance counter");

    // R9 invalidate all
    ctrl_write(cw(20, 0, 1));
    lookup(32'h0040_0ABC, 8'h11, 1'b1, 2'd1, 6'd0, 29'h0, 9'h0, "R9 flushed entry misses");
    lookup(32'h0300_0010, 8'h44, 1'b0, 2'd1, 6'd0, 29'h0, 9'h0, "R9 flushed loaded entry");
    ctrl_write(cw(20, 0, 0));
    load_entry(32'h0080_0011, 32'h00AB_C140);
    lookup(32'h0080_0123, 8'h11, 1'b0, 2'd0, 6'd20, 29'h00AB_C123, 9'h140, "R6 R1 load at index 20");

    repeat (3) @(negedge clk_i);
    chk(sb_q.size() == 0, "R5 all results seen", sb_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule